// File: doc/BRIEF.md
# Stereo Digital Volume Attenuator

This block scales a stereo stream of 18-bit signed PCM samples, one left/right pair per input strobe. Each channel gets its own 8-bit attenuation code. Every code step lowers the level by 0.5 dB below full scale. Both codes sit in one 16-bit volume register that software can write and read back.

The block also has the following controls:

- A mute input for each channel.
- An automatic mute of both channels whenever the upstream decoder reports bad data or a sample underrun.
- An analog power-enable output. It drops only when both codes are at their maximum.

A soft reset flushes the sample pipeline and leaves the programmed volume alone. The hardware reset returns the register to full volume.

The gain is built from two parts. A power-of-two shift handles each 6 dB group of 12 codes. One of twelve fixed-point multipliers covers the remaining fine step.

Top module: `stereo_vol_atten`

## Requirements
- R1: The volume register holds the right-channel code in bits 7:0 and the left-channel code in bits 15:8. A write with `reg_wr` high stores `reg_wdata`, and `reg_rdata` shows the stored value from the next cycle on.
- R2: After the hardware reset the register reads 0x0000 (full volume on both channels). In the same state `out_valid`, both output samples and both mute flags are 0, and `apwr_en` is 1.
- R3: A soft reset (`soft_rst` high for a cycle) leaves the register value unchanged. It clears `out_valid`, both output samples and both mute flags. It also discards any sample that is still inside the pipeline.
- R4: For a code c and an input sample x, the output is computed as follows.
  - Let s = floor(c/12) and k = c mod 12.
  - Let M[k] be taken from this list, for k = 0 to 11: 65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792. Each entry is 10^(-k/40) scaled by 2^16.
  - The output is floor((x·M[k] + 2^(15+s)) / 2^(16+s)), a round-half-up to 18 bits.
  - Code 0 therefore passes x unchanged.
- R5: The left output depends only on the left sample and the left code. The right output depends only on the right sample and the right code.
- R6: A pair accepted with `in_valid` at clock edge n appears at the outputs after edge n+1, with `out_valid` high for one cycle. `out_valid` stays low after edge n.
- R7: A pair uses the register value held just before its accepting edge. A write at that same edge, or at any later edge, does not change the pair; it applies from the next accepted pair on.
- R8: A channel whose mute input is high at the accepting edge outputs exactly 0 with its mute flag high. The other channel is not affected.
- R9: If `dec_bad` or `dec_underrun` is high at the accepting edge, both channels output exactly 0 and both mute flags are high.
- R10: `apwr_en` is low exactly while the register holds 0xFFFF. The value 0xFEFE, or any other value, keeps it high.
- R11: Code 255 yields an output of 0 for every input sample.
- R12: Between output pulses, the output samples and mute flags keep the values of the last output pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Soft reset; flushes the datapath and keeps the volume |
| reg_wr | input | 1 | Volume register write strobe |
| reg_wdata | input | 16 | Volume register write data |
| reg_rdata | output | 16 | Volume register read data |
| in_valid | input | 1 | Input sample pair strobe |
| in_left | input | 18 | Left input sample, signed |
| in_right | input | 18 | Right input sample, signed |
| usr_mute_l | input | 1 | User mute for the left channel |
| usr_mute_r | input | 1 | User mute for the right channel |
| dec_bad | input | 1 | Decoder reports invalid output |
| dec_underrun | input | 1 | Input samples arrived too late |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 18 | Attenuated left sample, signed |
| out_right | output | 18 | Attenuated right sample, signed |
| mute_l | output | 1 | Left channel muted for the current output pair |
| mute_r | output | 1 | Right channel muted for the current output pair |
| apwr_en | output | 1 | Analog power enable |

## Verification
A wrong stored volume shows at the next output pulse, two edges after the pair is accepted. It appears as a sample value that differs from the gain law for that code. A register corrupted by soft reset shows at once on `reg_rdata`, and `apwr_en` shows it too if the value crosses 0xFFFF. A code captured into the pipeline at the wrong edge, or a lost mute bit, appears only on the pair it belongs to. For that reason every output pulse is compared against a model that tracks the register, the mute inputs and the decoder flags.

// File: rtl/svat_pkg.sv
package svat_pkg;
    localparam int SMP_W         = 18;
    localparam int CODE_W        = 8;
    localparam int NCH           = 2;
    localparam int VOL_W         = NCH * CODE_W;
    localparam int CH_R          = 0;   // register bits 7:0
    localparam int CH_L          = 1;   // register bits 15:8
    localparam int STEPS_PER_6DB = 12;
    localparam int COEF_FRAC     = 16;
    localparam int COEF_W        = COEF_FRAC + 1;
    localparam int MAX_CODE      = (1 << CODE_W) - 1;
    localparam int MAX_SHIFT     = MAX_CODE / STEPS_PER_6DB;
    localparam int ACC_W         = SMP_W + COEF_W + MAX_SHIFT + 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [CODE_W-1:0]       code_t;
    typedef logic [VOL_W-1:0]        vol_t;

    // One captured channel: sample, code in force, mute decision
    typedef struct packed {
        smp_t  smp;
        code_t code;
        logic  mute;
    } lane_t;

    // Fine-step multiplier 10^(-k/40) in unsigned Q1.16
    function automatic logic [COEF_W-1:0] fine_coef(input int k);
        case (k)
            1:       fine_coef = COEF_W'(61870);
            2:       fine_coef = COEF_W'(58409);
            3:       fine_coef = COEF_W'(55142);
            4:       fine_coef = COEF_W'(52057);
            5:       fine_coef = COEF_W'(49145);
            6:       fine_coef = COEF_W'(46396);
            7:       fine_coef = COEF_W'(43801);
            8:       fine_coef = COEF_W'(41350);
            9:       fine_coef = COEF_W'(39037);
            10:      fine_coef = COEF_W'(36854);
            11:      fine_coef = COEF_W'(34792);
            default: fine_coef = COEF_W'(65536);
        endcase
    endfunction
endpackage

// File: rtl/svat_volreg.sv
module svat_volreg
    import svat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  vol_t wr_data,
    output vol_t vol,
    output logic pwr_en
);
    // Only the hardware reset touches the stored volume
    always_ff @(posedge clk) begin
        if (rst)        vol <= '0;
        else if (wr_en) vol <= wr_data;
    end

    // Both codes at maximum switches the analog side off
    assign pwr_en = ~(&vol);
endmodule

// File: rtl/svat_mute_ctrl.sv
module svat_mute_ctrl
    import svat_pkg::*;
(
    input  logic [NCH-1:0] usr_mute,
    input  logic           dec_bad,
    input  logic           dec_underrun,
    output logic [NCH-1:0] mute
);
    logic auto_mute;
    assign auto_mute = dec_bad | dec_underrun;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign mute[ch] = usr_mute[ch] | auto_mute;
    end
endmodule

// File: rtl/svat_chan_gain.sv
module svat_chan_gain
    import svat_pkg::*;
(
    input  smp_t  din,
    input  code_t code,
    output smp_t  dout
);
    int coarse;
    int fine;
    int total_sh;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] m_ext;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] half;
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        coarse   = int'(code) / STEPS_PER_6DB;
        fine     = int'(code) % STEPS_PER_6DB;
        total_sh = COEF_FRAC + coarse;
        x_ext    = {{(ACC_W-SMP_W){din[SMP_W-1]}}, din};
        m_ext    = {{(ACC_W-COEF_W){1'b0}}, fine_coef(fine)};
        prod     = x_ext * m_ext;
        half     = ACC_W'(1) << (total_sh - 1);
        sum      = prod + half;
        dout     = smp_t'(sum >>> total_sh);
    end
endmodule

// File: rtl/stereo_vol_atten.sv
module stereo_vol_atten
    import svat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [VOL_W-1:0]  reg_wdata,
    output logic [VOL_W-1:0]  reg_rdata,
    input  logic              in_valid,
    input  logic signed [SMP_W-1:0] in_left,
    input  logic signed [SMP_W-1:0] in_right,
    input  logic              usr_mute_l,
    input  logic              usr_mute_r,
    input  logic              dec_bad,
    input  logic              dec_underrun,
    output logic              out_valid,
    output logic signed [SMP_W-1:0] out_left,
    output logic signed [SMP_W-1:0] out_right,
    output logic              mute_l,
    output logic              mute_r,
    output logic              apwr_en
);
    vol_t                vol;
    logic [NCH-1:0]      usr_mute;
    logic [NCH-1:0]      mute_req;
    smp_t [NCH-1:0]      in_smp;
    lane_t [NCH-1:0]     cap_q;
    logic                cap_v;
    smp_t [NCH-1:0]      gain_out;
    smp_t [NCH-1:0]      o_smp;
    logic [NCH-1:0]      o_mute;
    logic                o_v;
    logic                flush;

    assign flush = rst | soft_rst;

    assign in_smp[CH_L]   = in_left;
    assign in_smp[CH_R]   = in_right;
    assign usr_mute[CH_L] = usr_mute_l;
    assign usr_mute[CH_R] = usr_mute_r;

    svat_volreg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .wr_data(reg_wdata),
        .vol    (vol),
        .pwr_en (apwr_en)
    );

    svat_mute_ctrl u_mute (
        .usr_mute    (usr_mute),
        .dec_bad     (dec_bad),
        .dec_underrun(dec_underrun),
        .mute        (mute_req)
    );

    // Capture stage: the pair freezes its code and mute here
    always_ff @(posedge clk) begin
        if (flush) begin
            cap_v <= 1'b0;
            cap_q <= '0;
        end else begin
            cap_v <= in_valid;
            if (in_valid) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    cap_q[ch].smp  <= in_smp[ch];
                    cap_q[ch].code <= vol[ch*CODE_W +: CODE_W];
                    cap_q[ch].mute <= mute_req[ch];
                end
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_gain
        svat_chan_gain u_gain (
            .din (cap_q[ch].smp),
            .code(cap_q[ch].code),
            .dout(gain_out[ch])
        );
    end

    // Output stage: holds the last pair between strobes
    always_ff @(posedge clk) begin
        if (flush) begin
            o_v    <= 1'b0;
            o_smp  <= '0;
            o_mute <= '0;
        end else begin
            o_v <= cap_v;
            if (cap_v) begin
                for (int ch = 0; ch < NCH; ch++) begin
                    o_smp[ch]  <= cap_q[ch].mute ? '0 : gain_out[ch];
                    o_mute[ch] <= cap_q[ch].mute;
                end
            end
        end
    end

    assign reg_rdata = vol;
    assign out_valid = o_v;
    assign out_left  = o_smp[CH_L];
    assign out_right = o_smp[CH_R];
    assign mute_l    = o_mute[CH_L];
    assign mute_r    = o_mute[CH_R];
endmodule

// File: rtl/svat_checker.sv
module svat_checker
    import svat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              reg_wr,
    input logic [VOL_W-1:0]  reg_wdata,
    input logic [VOL_W-1:0]  reg_rdata,
    input logic              in_valid,
    input logic signed [SMP_W-1:0] in_left,
    input logic signed [SMP_W-1:0] in_right,
    input logic              usr_mute_l,
    input logic              usr_mute_r,
    input logic              dec_bad,
    input logic              dec_underrun,
    input logic              out_valid,
    input logic signed [SMP_W-1:0] out_left,
    input logic signed [SMP_W-1:0] out_right,
    input logic              mute_l,
    input logic              mute_r,
    input logic              apwr_en
);
    // R1
    a_r1_write_readback: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata == $past(reg_wdata));

    // R2
    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata == '0 && !out_valid && apwr_en && !mute_l && !mute_r));

    // R3
    a_r3_soft_keeps_volume: assert property (@(posedge clk) disable iff (rst)
        (soft_rst && !reg_wr) |=> ($stable(reg_rdata) && !out_valid && !mute_l && !mute_r
                                   && out_left == '0 && out_right == '0));

    // R4: code 0 on the left passes the sample through
    a_r4_unity_left: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !soft_rst && reg_rdata[VOL_W-1:CODE_W] == '0 && !usr_mute_l
         && !dec_bad && !dec_underrun) ##1 !soft_rst |=> (out_valid && out_left == $past(in_left, 2)));

    // R8
    a_r8_mute_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((!mute_l || out_left == '0) && (!mute_r || out_right == '0)));

    // R9
    a_r9_auto_mute: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !soft_rst && (dec_bad || dec_underrun)) ##1 !soft_rst
        |=> (out_valid && mute_l && mute_r));

    // R10
    a_r10_power: assert property (@(posedge clk) disable iff (rst)
        apwr_en == (reg_rdata != {VOL_W{1'b1}}));

    // R5: the right channel reacts only to its own mute when no auto-mute is present
    a_r5_right_own_mute: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !soft_rst && !usr_mute_r && !dec_bad && !dec_underrun) ##1 !soft_rst
        |=> (out_valid && !mute_r));
endmodule

bind stereo_vol_atten svat_checker u_chk (.*);

// File: tb/sim_stereo_vol_atten.sv
`timescale 1ns/1ps
module sim_stereo_vol_atten;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic soft_rst = 1'b0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic in_valid = 1'b0;
    logic signed [17:0] in_left = '0;
    logic signed [17:0] in_right = '0;
    logic usr_mute_l = 1'b0;
    logic usr_mute_r = 1'b0;
    logic dec_bad = 1'b0;
    logic dec_underrun = 1'b0;
    logic out_valid;
    logic signed [17:0] out_left;
    logic signed [17:0] out_right;
    logic mute_l;
    logic mute_r;
    logic apwr_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] model_vol = '0;

    always #2.5 clk = ~clk;

    stereo_vol_atten u0 (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Multiplier list from R4
    function automatic longint coef_m(input int k);
        case (k)
            0: return 65536;  1: return 61870;  2: return 58409;  3: return 55142;
            4: return 52057;  5: return 49145;  6: return 46396;  7: return 43801;
            8: return 41350;  9: return 39037; 10: return 36854; default: return 34792;
        endcase
    endfunction

    function automatic longint exp_gain(input longint x, input int code);
        int sh;
        sh = 16 + code / 12;
        return (x * coef_m(code % 12) + (64'sd1 <<< (sh - 1))) >>> sh;
    endfunction

    task automatic write_vol(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        model_vol = v;
        check(reg_rdata == v, "R1 readback", reg_rdata, v);
        check(apwr_en == (v != 16'hFFFF), "R10 power enable", apwr_en, v != 16'hFFFF);
    endtask

    task automatic send(input logic signed [17:0] l, input logic signed [17:0] r,
                        input bit ml, input bit mr, input bit db, input bit du);
        bit am;
        longint el, er;
        am = db | du;
        el = (ml | am) ? 0 : exp_gain(l, int'(model_vol[15:8]));
        er = (mr | am) ? 0 : exp_gain(r, int'(model_vol[7:0]));
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        usr_mute_l = ml; usr_mute_r = mr; dec_bad = db; dec_underrun = du;
        @(negedge clk);
        in_valid = 1'b0; usr_mute_l = 1'b0; usr_mute_r = 1'b0; dec_bad = 1'b0; dec_underrun = 1'b0;
        check(out_valid == 1'b0, "R6 no early strobe", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R6 strobe", out_valid, 1);
        check(out_left == el, "R4/R5/R8/R9 left", out_left, el);
        check(out_right == er, "R4/R5/R8/R9 right", out_right, er);
        check(mute_l == (ml | am), "R8/R9 left flag", mute_l, ml | am);
        check(mute_r == (mr | am), "R8/R9 right flag", mute_r, mr | am);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic signed [17:0] hl;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check(reg_rdata == 16'h0000, "R2 volume", reg_rdata, 0);
        check(out_valid == 1'b0, "R2 out_valid", out_valid, 0);
        check(out_left == 0 && out_right == 0, "R2 samples", out_left, 0);
        check(mute_l == 0 && mute_r == 0, "R2 flags", mute_l, 0);
        check(apwr_en == 1'b1, "R2 power", apwr_en, 1);

        // R4 unity at code 0, both extremes
        send(18'sh1FFFF, -18'sh20000, 0, 0, 0, 0);
        send(-18'sd1, 18'sd1, 0, 0, 0, 0);
        // R12 hold between strobes
        hl = out_left;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 single pulse", out_valid, 0);
        check(out_left == hl, "R12 hold", out_left, hl);

        // R1 / R5 different codes per side
        write_vol(16'h0407);
        send(18'sd100000, 18'sd100000, 0, 0, 0, 0);
        write_vol(16'h0C18);
        send(-18'sd77777, 18'sd65432, 0, 0, 0, 0);

        // R8 per-channel user mute
        send(18'sd5000, 18'sd5000, 1, 0, 0, 0);
        send(18'sd5000, 18'sd5000, 0, 1, 0, 0);
        // R9 automatic mute
        send(18'sd9000, -18'sd9000, 0, 0, 1, 0);
        send(18'sd9000, -18'sd9000, 0, 0, 0, 1);

        // R10 / R11
        write_vol(16'hFEFE);
        send(18'sh1FFFF, -18'sh20000, 0, 0, 0, 0);
        write_vol(16'hFFFF);
        send(18'sh1FFFF, -18'sh20000, 0, 0, 0, 0);
        check(out_left == 0 && out_right == 0, "R11 code 255 silent", out_left, 0);

        // R3 soft reset after an output
        write_vol(16'h0A0B);
        send(18'sd4444, 18'sd3333, 1, 0, 0, 0);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(reg_rdata == 16'h0A0B, "R3 volume kept", reg_rdata, 16'h0A0B);
        check(out_left == 0 && out_right == 0, "R3 samples cleared", out_right, 0);
        check(mute_l == 0, "R3 flags cleared", mute_l, 0);
        // R3 in-flight pair discarded
        @(negedge clk);
        in_valid = 1'b1; in_left = 18'sd1000; in_right = 18'sd1000;
        @(negedge clk);
        in_valid = 1'b0; soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(out_valid == 1'b0, "R3 pair discarded", out_valid, 0);

        // R7 write at the accepting edge does not affect that pair
        @(negedge clk);
        in_valid = 1'b1; in_left = 18'sd50000; in_right = -18'sd50000;
        reg_wr = 1'b1; reg_wdata = 16'h3030;
        @(negedge clk);
        in_valid = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        check(out_left == exp_gain(50000, 16'h0A), "R7 same-edge write", out_left, exp_gain(50000, 16'h0A));
        check(out_right == exp_gain(-50000, 16'h0B), "R7 same-edge write", out_right, exp_gain(-50000, 16'h0B));
        model_vol = 16'h3030;
        // R7 write while the pair is in flight
        @(negedge clk);
        in_valid = 1'b1; in_left = 18'sd60000; in_right = 18'sd60000;
        @(negedge clk);
        in_valid = 1'b0; reg_wr = 1'b1; reg_wdata = 16'h5050;
        @(negedge clk);
        reg_wr = 1'b0;
        check(out_left == exp_gain(60000, 16'h30), "R7 in-flight write", out_left, exp_gain(60000, 16'h30));
        model_vol = 16'h5050;
        send(18'sd60000, 18'sd60000, 0, 0, 0, 0);

        // Constrained random
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel == 0) write_vol(16'h0000);
            else if (sel == 1) write_vol(16'hFFFF);
            else if (sel == 2) write_vol(16'hFEFE);
            else if (sel < 6) write_vol(16'($urandom));
            send(18'($urandom), 18'($urandom),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule